// File: doc/BRIEF.md
# Program Counter and Memory Address Generator

This unit produces every address a small 16-bit stored-program processor needs. One adder forms the effective address. Its left operand is either the current program counter or a register value supplied from outside. Its right operand is one of three things taken from the instruction word: zero, a sign-extended 6-bit field, or a sign-extended 9-bit field. The sum is always visible on `ea_o`, so an instruction that only computes an address (load-effective-address) can write it back to a register without starting a memory access.

The unit holds two registers. The program counter is loaded through a four-way next-PC selector: increment, adder, bus or hold. The memory address register is loaded through a two-way selector: the adder, or an 8-bit service-routine vector from the instruction, zero-extended. A control sequencer outside the unit drives all of the select and load strobes. Memory, the register file and the sequencer are not part of the unit.

Top module: `pcmar_addr_unit`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it, `pc_o` is x3000 and `mar_o` is x0000.
- R2: `pc_sel_i`=00 with `ld_pc_i` high loads `pc_o`+1 modulo 2^16, so xFFFF becomes x0000.
- R3: `addr1_sel_i`=0 selects `pc_o` as the left operand, and `addr2_sel_i`=10 selects the sign extension of `ir_i[8:0]`. `ea_o` is then `pc_o`+sext(`ir_i[8:0]`) modulo 2^16 in the same cycle. Example: a PC of x30F7 with field x1FD gives x30F4.
- R4: `addr1_sel_i`=1 selects `base_i`, and `addr2_sel_i`=01 selects the sign extension of `ir_i[5:0]`. `ea_o` is `base_i`+sext(`ir_i[5:0]`) modulo 2^16, and `ir_i[15:6]` has no effect on the sum.
- R5: `addr2_sel_i`=00 or 11 adds zero, so `ea_o` equals the selected left operand. This is the path for a register jump.
- R6: With `ld_pc_i` high, `pc_sel_i`=01 loads `ea_o`, 10 loads `bus_i`, and 11 leaves `pc_o` unchanged. `next_pc_o` always shows the value that would be loaded.
- R7: With `ld_mar_i` high, `mar_sel_i`=0 loads `ea_o` into `mar_o`, and `mar_sel_i`=1 loads {8'h00, `ir_i[7:0]`}.
- R8: With `ld_pc_i` low, `pc_o` holds whatever `pc_sel_i` and `bus_i` are. With `ld_mar_i` low, `mar_o` holds.
- R9: All address sums wrap modulo 2^16. For example, xFFF0+sext(x1F) gives x000F, and x0000+sext(x1FF) gives xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_i | input | 16 | Current instruction word |
| base_i | input | 16 | Register value for base+offset or jump |
| bus_i | input | 16 | Shared data bus value |
| addr1_sel_i | input | 1 | Adder left operand: 0 PC, 1 base_i |
| addr2_sel_i | input | 2 | Adder right operand: 00/11 zero, 01 sext 6-bit, 10 sext 9-bit |
| pc_sel_i | input | 2 | Next PC: 00 PC+1, 01 adder, 10 bus, 11 hold |
| ld_pc_i | input | 1 | Program counter load enable |
| mar_sel_i | input | 1 | MAR source: 0 adder, 1 zero-extended ir_i[7:0] |
| ld_mar_i | input | 1 | MAR load enable |
| pc_o | output | 16 | Program counter |
| next_pc_o | output | 16 | Value the PC would load |
| mar_o | output | 16 | Memory address register |
| ea_o | output | 16 | Effective address (adder output) |

## Verification
The adder is driven with both left operands and with every offset code. Each offset field is tested with a positive value and a negative value, which separates sign extension from zero extension and separates the 6-bit field from the 9-bit field. Stray upper instruction bits are set during base+offset sums to show that only the selected field reaches the adder. Sums are placed just across the 2^16 boundary in both directions to expose carry handling. Each PC source and each MAR source is loaded with a distinct value, and loads with the enable low are interleaved, so a swapped selector or an ignored enable produces a visibly wrong register value.

// File: rtl/pcmar_addr_unit.sv
module pcmar_addr_unit #(
  parameter int W        = 16,
  parameter int OFS_S    = 6,
  parameter int OFS_L    = 9,
  parameter int VEC_W    = 8,
  parameter logic [W-1:0] PC_RESET = 16'h3000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ir_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] bus_i,
  input  logic         addr1_sel_i,
  input  logic [1:0]   addr2_sel_i,
  input  logic [1:0]   pc_sel_i,
  input  logic         ld_pc_i,
  input  logic         mar_sel_i,
  input  logic         ld_mar_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] next_pc_o,
  output logic [W-1:0] mar_o,
  output logic [W-1:0] ea_o
);
  logic [W-1:0] left_op, right_op, off_s, off_l, vec_z, mar_d;

  assign off_s   = {{(W-OFS_S){ir_i[OFS_S-1]}}, ir_i[OFS_S-1:0]};
  assign off_l   = {{(W-OFS_L){ir_i[OFS_L-1]}}, ir_i[OFS_L-1:0]};
  assign vec_z   = {{(W-VEC_W){1'b0}}, ir_i[VEC_W-1:0]};
  assign left_op = addr1_sel_i ? base_i : pc_o;

  always_comb begin
    case (addr2_sel_i)
      2'b01:   right_op = off_s;
      2'b10:   right_op = off_l;
      default: right_op = '0;
    endcase
  end

  assign ea_o = left_op + right_op;

  always_comb begin
    case (pc_sel_i)
      2'b00:   next_pc_o = pc_o + W'(1);
      2'b01:   next_pc_o = ea_o;
      2'b10:   next_pc_o = bus_i;
      default: next_pc_o = pc_o;
    endcase
  end

  assign mar_d = mar_sel_i ? vec_z : ea_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o  <= PC_RESET;
      mar_o <= '0;
    end else begin
      if (ld_pc_i)  pc_o  <= next_pc_o;
      if (ld_mar_i) mar_o <= mar_d;
    end
  end
endmodule

module pcmar_addr_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ir_i,
  input logic [W-1:0] base_i,
  input logic [W-1:0] bus_i,
  input logic         addr1_sel_i,
  input logic [1:0]   addr2_sel_i,
  input logic [1:0]   pc_sel_i,
  input logic         ld_pc_i,
  input logic         mar_sel_i,
  input logic         ld_mar_i,
  input logic [W-1:0] pc_o,
  input logic [W-1:0] mar_o,
  input logic [W-1:0] ea_o
);
  a_r2_pc_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc_i && pc_sel_i == 2'b00) |=> pc_o == W'($past(pc_o) + W'(1)));

  a_r5_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (addr1_sel_i && (addr2_sel_i == 2'b00 || addr2_sel_i == 2'b11)) |-> ea_o == base_i);

  a_r6_bus_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc_i && pc_sel_i == 2'b10) |=> pc_o == $past(bus_i));

  a_r6_adder_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pc_i && pc_sel_i == 2'b01) |=> pc_o == $past(ea_o));

  a_r7_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mar_i && mar_sel_i) |=> (mar_o[W-1:8] == '0 && mar_o[7:0] == $past(ir_i[7:0])));

  a_r7_adder_to_mar: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mar_i && !mar_sel_i) |=> mar_o == $past(ea_o));

  a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_pc_i |=> $stable(pc_o));

  a_r8_mar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mar_i |=> $stable(mar_o));
endmodule

bind pcmar_addr_unit pcmar_addr_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_i(ir_i), .base_i(base_i), .bus_i(bus_i),
  .addr1_sel_i(addr1_sel_i), .addr2_sel_i(addr2_sel_i), .pc_sel_i(pc_sel_i),
  .ld_pc_i(ld_pc_i), .mar_sel_i(mar_sel_i), .ld_mar_i(ld_mar_i),
  .pc_o(pc_o), .mar_o(mar_o), .ea_o(ea_o)
);

// File: tb/pcmar_addr_unit_tb.sv
module pcmar_addr_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ir = '0, base = '0, bus = '0;
  logic a1 = 1'b0, ldpc = 1'b0, msel = 1'b0, ldmar = 1'b0;
  logic [1:0] a2 = '0, psel = '0;
  logic [15:0] pc_o, next_pc_o, mar_o, ea_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] ea;
    logic [15:0] pc;
    logic [15:0] mar;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] pc_m, mar_m;

  always #2.5 clk = ~clk;

  pcmar_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ir_i(ir), .base_i(base), .bus_i(bus),
    .addr1_sel_i(a1), .addr2_sel_i(a2), .pc_sel_i(psel), .ld_pc_i(ldpc),
    .mar_sel_i(msel), .ld_mar_i(ldmar),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .mar_o(mar_o), .ea_o(ea_o)
  );

  function automatic logic [15:0] sx(input int n, input logic [15:0] v);
    logic signed [15:0] t;
    t = $signed(v << (16 - n));
    return 16'(t >>> (16 - n));
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] i_ir, input logic [15:0] i_base,
                      input logic [15:0] i_bus, input logic i_a1,
                      input logic [1:0] i_a2, input logic [1:0] i_psel,
                      input logic i_ldpc, input logic i_msel,
                      input logic i_ldmar, input string tag);
    exp_t e;
    logic [15:0] l, r, np;
    @(negedge clk);
    ir = i_ir; base = i_base; bus = i_bus; a1 = i_a1; a2 = i_a2;
    psel = i_psel; ldpc = i_ldpc; msel = i_msel; ldmar = i_ldmar;
    l = i_a1 ? i_base : pc_m;
    r = (i_a2 == 2'b01) ? sx(6, i_ir) : (i_a2 == 2'b10) ? sx(9, i_ir) : 16'h0000;
    e.ea = 16'(l + r);
    case (i_psel)
      2'b00:   np = 16'(pc_m + 16'd1);
      2'b01:   np = e.ea;
      2'b10:   np = i_bus;
      default: np = pc_m;
    endcase
    if (i_ldpc) pc_m = np;
    if (i_ldmar) mar_m = i_msel ? {8'h00, i_ir[7:0]} : e.ea;
    e.pc = pc_m;
    e.mar = mar_m;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(e.tag, "ea", ea_o, e.ea);
        @(posedge clk);
        #1;
        check(e.tag, "pc", pc_o, e.pc);
        check(e.tag, "mar", mar_o, e.mar);
      end
    end
  end

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    pc_m = 16'h3000;
    mar_m = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset pc", pc_o, 16'h3000);
    check("R1", "reset mar", mar_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: no loads right after reset
    step(16'h0000, 16'h0000, 16'h0000, 0, 2'b00, 2'b00, 0, 0, 0, "R1");
    // R2: increment from x3000
    step(16'h0000, 16'h0000, 16'h0000, 0, 2'b00, 2'b00, 1, 0, 0, "R2");
    // R6: bus load to x30F7
    step(16'h0000, 16'h0000, 16'h30F7, 0, 2'b00, 2'b10, 1, 0, 0, "R6");
    // R3: PC-relative offset -3 gives x30F4, into MAR (R7)
    step(16'hE3FD, 16'h0000, 16'h0000, 0, 2'b10, 2'b00, 0, 0, 1, "R3");
    // R3: positive 9-bit offset xFF
    step(16'hE0FF, 16'h0000, 16'h0000, 0, 2'b10, 2'b00, 0, 0, 1, "R3");
    // R6: branch, adder into PC
    step(16'h0E05, 16'h0000, 16'h0000, 0, 2'b10, 2'b01, 1, 0, 0, "R6");
    // R4: base+offset +14, upper IR bits set
    step(16'h7F8E, 16'h3102, 16'h0000, 1, 2'b01, 2'b11, 0, 0, 1, "R4");
    // R4: negative 6-bit offset -32
    step(16'h6FE0, 16'h4000, 16'h0000, 1, 2'b01, 2'b11, 0, 0, 1, "R4");
    // R5: jump, zero offset, code 00
    step(16'hC1FF, 16'hABCD, 16'h0000, 1, 2'b00, 2'b01, 1, 0, 0, "R5");
    // R5: zero offset, code 11
    step(16'hFFFF, 16'h1234, 16'h0000, 1, 2'b11, 2'b11, 1, 0, 1, "R5");
    // R7: trap vector x25, zero-extended
    step(16'hF025, 16'h0000, 16'h0000, 0, 2'b10, 2'b00, 0, 1, 1, "R7");
    // R7: trap vector xFF
    step(16'hF0FF, 16'h0000, 16'h0000, 0, 2'b10, 2'b00, 0, 1, 1, "R7");
    // R8: enables low, selectors and bus active
    step(16'hF0AA, 16'h5555, 16'hDEAD, 1, 2'b01, 2'b10, 0, 1, 0, "R8");
    step(16'h0000, 16'h7777, 16'hBEEF, 1, 2'b00, 2'b01, 0, 0, 0, "R8");
    // R6: hold code 11 with load high
    step(16'h0000, 16'h0000, 16'hBEEF, 0, 2'b00, 2'b11, 1, 0, 0, "R6");
    // R2: wrap xFFFF to x0000
    step(16'h0000, 16'h0000, 16'hFFFF, 0, 2'b00, 2'b10, 1, 0, 0, "R2");
    step(16'h0000, 16'h0000, 16'h0000, 0, 2'b00, 2'b00, 1, 0, 0, "R2");
    // R9: x0000 + sext(x1FF) = xFFFF
    step(16'h01FF, 16'h0000, 16'h0000, 0, 2'b10, 2'b01, 1, 0, 1, "R9");
    // R9: xFFF0 + sext(x1F) = x000F
    step(16'h001F, 16'hFFF0, 16'h0000, 1, 2'b01, 2'b00, 0, 0, 1, "R9");
    // R3: PC operand with the 6-bit field
    step(16'h003E, 16'h0000, 16'h0000, 0, 2'b01, 2'b00, 0, 0, 1, "R3");
    step(16'h0000, 16'h0000, 16'h0000, 0, 2'b00, 2'b11, 0, 0, 0, "R8");
    repeat (4) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule